// File: doc/BRIEF.md
# Bidirectional Port with Dual Handshake and Shared Interrupt

This block is one 8-bit peripheral port that carries data both ways. The peripheral chooses the direction of each transfer through two separate strobe/ready pairs. The inbound pair moves a byte from the peripheral pins into a holding buffer that the CPU reads. The outbound pair hands a byte that the CPU wrote to the peripheral. Both directions raise one interrupt line. The CPU reads a small status word to learn whether a received byte is waiting, whether the peripheral is asking for more data, or both.

Each strobe/ready pair works as a valid/ready stream with back-pressure. On the inbound side, `in_rdy` high means the buffer is empty. A rising strobe while `in_rdy` is high captures the pins. A rising strobe while `in_rdy` is low is refused, and the held byte stays intact. The buffer is released only when the CPU reads it. On the outbound side, `out_rdy` high means a CPU byte is valid on the pins. A rising outbound strobe is the peripheral's acknowledge and request for the next byte. The next CPU write is the only thing that raises `out_rdy` again.

At reset `in_rdy` is low. Software must do one dummy read of the data register before the first inbound transfer can take place. The CPU bus is a plain select/read/write interface. Read data is combinational during the read cycle. Side effects take place at the clock edge that ends that cycle.

Top module: `bidir_hs_port`

## Requirements
- R1: After reset, `in_rdy`, `out_rdy`, `irq` and `pin_oe` are 0, and a status read returns 0.
- R2: A rising edge of `in_stb` while `in_rdy` is 1 captures `pin_in` into the inbound buffer at that clock edge. After that edge `in_rdy` is 0 and status bit 0 (inbound full) is 1.
- R3: A rising edge of `in_stb` while `in_rdy` is 0 is ignored. The buffer contents, `in_rdy` and status bit 0 are left unchanged.
- R4: A selected read of address 1 returns the inbound buffer. At the clock edge that ends the read, status bit 0 clears and `in_rdy` goes to 1. This also applies to a dummy read made after reset.
- R5: A selected write to address 1 latches `cpu_wdata` into the outbound buffer. After that edge `out_rdy` is 1 and status bit 1 (outbound request) is 0.
- R6: A rising edge of `out_stb` clears `out_rdy` and sets status bit 1.
- R7: `pin_out` always shows the outbound buffer. `pin_oe` is 1 exactly when `out_rdy` is 1 and `out_stb` is low; otherwise the pins are high-impedance.
- R8: `irq` is 1 whenever status bit 0 or status bit 1 is set.
- R9: A selected read of address 0 returns status with bit 0 = inbound full, bit 1 = outbound request, and all other bits 0. The read has no side effect.
- R10: In the same cycle, an inbound capture takes precedence over a CPU data read, so the new byte is held and `in_rdy` stays 0. A CPU data write takes precedence over an outbound strobe, so `out_rdy` is 1 and bit 1 is 0.
- R11: A strobe that is held high acts only once, at its rising edge.
- R12: Reads and writes with `cpu_sel` low have no effect. Addresses 2 and 3 read as 0 and ignore writes. Writes to address 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Chip select for CPU accesses |
| cpu_addr | input | 2 | Register select: 0 status, 1 data |
| cpu_rd | input | 1 | Read strobe (one cycle per access) |
| cpu_wr | input | 1 | Write strobe (one cycle per access) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, 0 when no selected read |
| pin_in | input | 8 | Port pins as seen by the block |
| pin_out | output | 8 | Value driven onto the port pins |
| pin_oe | output | 1 | Tri-state enable for `pin_out` |
| in_stb | input | 1 | Peripheral strobe for inbound data (active high) |
| in_rdy | output | 1 | Inbound buffer empty, ready to accept |
| out_stb | input | 1 | Peripheral acknowledge/request for outbound data (active high) |
| out_rdy | output | 1 | Outbound byte valid on the pins |
| irq | output | 1 | Shared interrupt |

## Verification
The bench first strobes the inbound side straight after reset, before any dummy read. A design that accepted that byte would overwrite data and set the full flag without leave. It holds a strobe high across a CPU read to catch a level-sensitive design, which would capture a second time at once. It then starts a read and a capture in the same cycle, and a write and an acknowledge in the same cycle. The wrong priority shows up as a lost byte or a stale request flag. Deselected, reserved-address and status accesses are each followed by status and pin observations. These show that none of them disturbs either buffer or clears a flag.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

  // Register select codes on the CPU bus
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_DATA   = 2'd1,
    REG_RSV2   = 2'd2,
    REG_RSV3   = 2'd3
  } reg_sel_e;

  // Status word bit positions
  localparam int ST_IN_FULL = 0;
  localparam int ST_OUT_REQ = 1;

endpackage

// File: rtl/bhp_strobe_edge.sv
module bhp_strobe_edge #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic evt_o,
  output logic act_o
);
  localparam logic IDLE_LVL = ACTIVE_HIGH ? 1'b0 : 1'b1;

  logic stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= IDLE_LVL;
    else        stb_q <= stb_i;
  end

  generate
    if (ACTIVE_HIGH) begin : g_high
      assign evt_o = stb_i & ~stb_q;
      assign act_o = stb_i;
    end else begin : g_low
      assign evt_o = ~stb_i & stb_q;
      assign act_o = ~stb_i;
    end
  endgenerate

  // An event lasts one cycle however long the strobe is held
  p_single_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);

endmodule

// File: rtl/bhp_in_side.sv
module bhp_in_side #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_evt_i,
  input  logic [DATA_W-1:0] pin_i,
  input  logic              rd_take_i,
  output logic              full_o,
  output logic              rdy_o,
  output logic [DATA_W-1:0] buf_o
);
  logic              full_q, rdy_q;
  logic [DATA_W-1:0] buf_q;
  logic              capture;

  // Back-pressure: a strobe only lands when the buffer is empty
  assign capture = stb_evt_i & rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      rdy_q  <= 1'b0;
      buf_q  <= '0;
    end else if (capture) begin
      buf_q  <= pin_i;
      full_q <= 1'b1;
      rdy_q  <= 1'b0;
    end else if (rd_take_i) begin
      full_q <= 1'b0;
      rdy_q  <= 1'b1;
    end
  end

  assign full_o = full_q;
  assign rdy_o  = rdy_q;
  assign buf_o  = buf_q;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_evt_i && rdy_q) |=> (full_q && !rdy_q && buf_q == $past(pin_i)));

  p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_evt_i && !rdy_q) |=> (buf_q == $past(buf_q)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take_i && !(stb_evt_i && rdy_q)) |=> (rdy_q && !full_q));

endmodule

// File: rtl/bhp_out_side.sv
module bhp_out_side #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_evt_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              req_o,
  output logic              rdy_o,
  output logic [DATA_W-1:0] buf_o
);
  logic              req_q, rdy_q;
  logic [DATA_W-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      rdy_q <= 1'b0;
      buf_q <= '0;
    end else if (wr_i) begin
      buf_q <= wdata_i;
      rdy_q <= 1'b1;
      req_q <= 1'b0;
    end else if (stb_evt_i) begin
      rdy_q <= 1'b0;
      req_q <= 1'b1;
    end
  end

  assign req_o = req_q;
  assign rdy_o = rdy_q;
  assign buf_o = buf_q;

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (rdy_q && !req_q && buf_q == $past(wdata_i)));

  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_evt_i && !wr_i) |=> (!rdy_q && req_q));

endmodule

// File: rtl/bidir_hs_port.sv
module bidir_hs_port #(
  parameter int DATA_W          = 8,
  parameter int ADDR_W          = 2,
  parameter bit STB_ACTIVE_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic              pin_oe,
  input  logic              in_stb,
  output logic              in_rdy,
  input  logic              out_stb,
  output logic              out_rdy,
  output logic              irq
);
  import bhp_pkg::*;

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(REG_DATA);

  logic              in_evt, in_act_unused;
  logic              out_evt, out_act;
  logic              rd_data, wr_data, rd_stat;
  logic              in_full, out_req;
  logic [DATA_W-1:0] in_buf, out_buf;
  logic [DATA_W-1:0] stat_word;

  // Bus decode
  assign rd_stat = cpu_sel & cpu_rd & (cpu_addr == A_STATUS);
  assign rd_data = cpu_sel & cpu_rd & (cpu_addr == A_DATA);
  assign wr_data = cpu_sel & cpu_wr & (cpu_addr == A_DATA);

  bhp_strobe_edge #(.ACTIVE_HIGH(STB_ACTIVE_HIGH)) u_in_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .stb_i (in_stb),
    .evt_o (in_evt),
    .act_o (in_act_unused)
  );

  bhp_strobe_edge #(.ACTIVE_HIGH(STB_ACTIVE_HIGH)) u_out_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .stb_i (out_stb),
    .evt_o (out_evt),
    .act_o (out_act)
  );

  bhp_in_side #(.DATA_W(DATA_W)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_evt_i (in_evt),
    .pin_i     (pin_in),
    .rd_take_i (rd_data),
    .full_o    (in_full),
    .rdy_o     (in_rdy),
    .buf_o     (in_buf)
  );

  bhp_out_side #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_evt_i (out_evt),
    .wr_i      (wr_data),
    .wdata_i   (cpu_wdata),
    .req_o     (out_req),
    .rdy_o     (out_rdy),
    .buf_o     (out_buf)
  );

  always_comb begin
    stat_word             = '0;
    stat_word[ST_IN_FULL] = in_full;
    stat_word[ST_OUT_REQ] = out_req;
  end

  always_comb begin
    cpu_rdata = '0;
    if (rd_stat)      cpu_rdata = stat_word;
    else if (rd_data) cpu_rdata = in_buf;
  end

  // Pins driven only while a valid byte waits and the peripheral is not strobing
  assign pin_out = out_buf;
  assign pin_oe  = out_rdy & ~out_act;
  assign irq     = in_full | out_req;

  // A new interrupt can only come from a peripheral strobe
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(in_evt) || $past(out_evt)));

  // Drive enable drops in the cycle the acknowledge strobe arrives
  p_oe_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_evt) |-> !pin_oe);

endmodule

// File: tb/bidir_hs_port_tb.sv
module bidir_hs_port_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_sel = 0, cpu_rd = 0, cpu_wr = 0;
  logic [1:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, pin_in = 0;
  logic       in_stb = 0, out_stb = 0;
  logic [7:0] cpu_rdata, pin_out;
  logic       pin_oe, in_rdy, out_rdy, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bidir_hs_port dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .in_stb(in_stb), .in_rdy(in_rdy),
    .out_stb(out_stb), .out_rdy(out_rdy), .irq(irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [7:0] m_in_buf, m_out_buf;
  logic m_in_full, m_in_rdy, m_out_req, m_out_rdy, m_prev_in, m_prev_out;

  always @(posedge clk) begin
    logic ie, oe_evt, was_rdy, exp_oe;
    int exp_rd;
    if (!rst_n) begin
      m_in_buf = 0; m_out_buf = 0; m_in_full = 0; m_in_rdy = 0;
      m_out_req = 0; m_out_rdy = 0; m_prev_in = 0; m_prev_out = 0;
    end else begin
      ie = in_stb && !m_prev_in;
      oe_evt = out_stb && !m_prev_out;
      was_rdy = m_in_rdy;
      if (cpu_sel && cpu_rd && cpu_addr == 2'd1) begin m_in_full = 0; m_in_rdy = 1; end
      if (ie && was_rdy) begin m_in_buf = pin_in; m_in_full = 1; m_in_rdy = 0; end
      if (oe_evt) begin m_out_rdy = 0; m_out_req = 1; end
      if (cpu_sel && cpu_wr && cpu_addr == 2'd1) begin
        m_out_buf = cpu_wdata; m_out_rdy = 1; m_out_req = 0;
      end
      m_prev_in = in_stb;
      m_prev_out = out_stb;
    end
    #(CLK_P/4);
    exp_rd = 0;
    if (cpu_sel && cpu_rd && cpu_addr == 2'd0) exp_rd = {m_out_req, m_in_full};
    if (cpu_sel && cpu_rd && cpu_addr == 2'd1) exp_rd = m_in_buf;
    exp_oe = m_out_rdy && !out_stb;
    check("R2", "model in_rdy", in_rdy, m_in_rdy);
    check("R5", "model out_rdy", out_rdy, m_out_rdy);
    check("R8", "model irq", irq, m_in_full | m_out_req);
    check("R7", "model pin_oe", pin_oe, exp_oe);
    check("R7", "model pin_out", pin_out, m_out_buf);
    check("R9", "model cpu_rdata", cpu_rdata, exp_rd);
  end

  task automatic rd_reg(input logic [1:0] a, input logic s, output logic [7:0] d);
    cpu_sel = s; cpu_rd = 1; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_sel = 0; cpu_rd = 0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic s, input logic [7:0] v);
    cpu_sel = s; cpu_wr = 1; cpu_addr = a; cpu_wdata = v;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic in_pulse(input logic [7:0] v);
    pin_in = v; in_stb = 1;
    @(negedge clk);
    in_stb = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "in_rdy", in_rdy, 0);
    check("R1", "out_rdy", out_rdy, 0);
    check("R1", "irq", irq, 0);
    check("R1", "pin_oe", pin_oe, 0);
    rd_reg(2'd0, 1, d); check("R1", "status", d, 0);

    // R3 strobe before dummy read is refused
    in_pulse(8'hA5);
    rd_reg(2'd0, 1, d); check("R3", "status after refused strobe", d, 0);
    check("R3", "in_rdy stays low", in_rdy, 0);

    // R4 dummy read releases the buffer
    rd_reg(2'd1, 1, d);
    check("R4", "in_rdy after dummy read", in_rdy, 1);

    // R2 capture
    in_pulse(8'h3C);
    check("R2", "in_rdy after capture", in_rdy, 0);
    check("R8", "irq after capture", irq, 1);
    rd_reg(2'd0, 1, d); check("R2", "status full", d, 1);
    rd_reg(2'd1, 1, d); check("R4", "read data", d, 8'h3C);
    check("R4", "in_rdy after read", in_rdy, 1);
    check("R8", "irq cleared", irq, 0);

    // R11 held strobe captures once
    pin_in = 8'h11; in_stb = 1;
    @(negedge clk);
    rd_reg(2'd1, 1, d); check("R11", "held strobe data", d, 8'h11);
    pin_in = 8'h22;
    @(negedge clk); @(negedge clk);
    check("R11", "no second capture", in_rdy, 1);
    rd_reg(2'd0, 1, d); check("R11", "status stays clear", d, 0);
    in_stb = 0;
    @(negedge clk);

    // R5, R7 outbound write
    wr_reg(2'd1, 1, 8'h5A);
    check("R5", "out_rdy", out_rdy, 1);
    check("R7", "pin_oe driven", pin_oe, 1);
    check("R7", "pin_out", pin_out, 8'h5A);
    out_stb = 1; #1;
    check("R7", "pin_oe off during strobe", pin_oe, 0);
    @(negedge clk);
    out_stb = 0;
    check("R6", "out_rdy after ack", out_rdy, 0);
    check("R8", "irq after ack", irq, 1);
    rd_reg(2'd0, 1, d); check("R6", "status req", d, 2);
    wr_reg(2'd1, 1, 8'h66);
    rd_reg(2'd0, 1, d); check("R5", "req cleared by write", d, 0);

    // R9 both flags, status read has no side effect
    in_pulse(8'h81);
    out_stb = 1; @(negedge clk); out_stb = 0;
    rd_reg(2'd0, 1, d); check("R9", "both flags", d, 3);
    rd_reg(2'd0, 1, d); check("R9", "status read twice", d, 3);
    rd_reg(2'd1, 1, d); check("R9", "data after status", d, 8'h81);

    // R10 capture beats read
    cpu_sel = 1; cpu_rd = 1; cpu_addr = 2'd1; pin_in = 8'hC3; in_stb = 1;
    @(negedge clk);
    cpu_sel = 0; cpu_rd = 0; in_stb = 0;
    check("R10", "in_rdy after collision", in_rdy, 0);
    rd_reg(2'd0, 1, d); check("R10", "full kept", d[0], 1);
    // R10 write beats acknowledge
    cpu_sel = 1; cpu_wr = 1; cpu_addr = 2'd1; cpu_wdata = 8'h77; out_stb = 1;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0; out_stb = 0;
    check("R10", "out_rdy after collision", out_rdy, 1);
    check("R10", "pin_out new", pin_out, 8'h77);
    rd_reg(2'd0, 1, d); check("R10", "req clear", d[1], 0);

    // R12 ignored accesses
    wr_reg(2'd1, 0, 8'hEE);
    check("R12", "deselected write", pin_out, 8'h77);
    wr_reg(2'd3, 1, 8'hEE);
    check("R12", "reserved write", pin_out, 8'h77);
    wr_reg(2'd0, 1, 8'hEE);
    check("R12", "status write", pin_out, 8'h77);
    rd_reg(2'd2, 1, d); check("R12", "reserved read", d, 0);
    rd_reg(2'd1, 0, d);
    check("R12", "deselected read keeps in_rdy", in_rdy, 0);
    rd_reg(2'd0, 1, d); check("R12", "status intact", d, 1);
    rd_reg(2'd1, 1, d); check("R12", "buffer intact", d, 8'hC3);

    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule